// File: doc/BRIEF.md
# Segment Descriptor Address Translator

This block turns a segmented virtual address into a flat linear address. A request supplies a 16-bit selector, a 32-bit offset, an access kind (read, write or execute) and the privilege level of the running code. The selector picks one descriptor from a small on-chip table, which holds one bank for the global table and one bank for the local table. The descriptor is then checked for presence, privilege, access kind and limit, in that order. If every check passes, the block returns base plus offset. If a check fails, it returns a 3-bit cause code instead.

A separate write port loads 64-bit descriptors into the table. Each result is registered, so it appears on the clock edge after the request. With paging off, the linear address can be used directly as the physical address.

Top module: `segx_top`

## Requirements
- R1: While `rst` is high and after it falls, until the first request, `rsp_valid`, `rsp_fault`, `rsp_lin` and `rsp_opsz` are all zero.
- R2: A request with `req_valid` high gives `rsp_valid` high on the next rising edge. A cycle without a request gives `rsp_valid` low and all other outputs zero on the next edge. Back-to-back requests each get their own response.
- R3: `rsp_fault` only takes these codes: 0 none, 1 not-present, 2 limit, 3 privilege, 4 type.
- R4: The selector is split as follows: bits [15:3] are the index, bit 2 selects the bank (0 global, 1 local), and bits [1:0] are the requestor level. The table entry used is {bank, index[IDX_W-1:0]}. An index of 2^IDX_W or more gives fault 1.
- R5: A descriptor whose present bit is clear gives fault 1.
- R6: Fault 3 is raised when the larger of `req_cpl` and the requestor level is numerically greater than the descriptor privilege level.
- R7: Access kinds are encoded 0 read, 1 write, 2 execute, 3 reserved. For a data segment, read is always allowed, write needs the permission bit, and execute faults. For a code segment, execute is allowed, read needs the permission bit, and write always faults. Kind 3 always faults. Each of these faults gives code 4.
- R8: The effective limit is the 20-bit limit when the granularity bit is clear. When it is set, it is the limit shifted left by 12 with the low 12 bits set to ones. An offset above the effective limit gives fault 2, and an offset equal to it passes.
- R9: On success, `rsp_fault` is 0 and `rsp_lin` is (base + offset) mod 2^32. On any fault, `rsp_lin` and `rsp_opsz` are 0.
- R10: When several checks fail, the lowest-numbered step below sets the code: (1) not-present or out-of-range index, (2) privilege, (3) type, (4) limit.
- R11: With `wr_en` high, `wr_desc` is stored at entry `wr_addr` = {bank, index} on the rising edge. The descriptor layout is: bit 63 present, [62:61] privilege level, 60 granularity, 59 operand size, 58 code, 57 permission, [56:52] unused, [51:32] limit, [31:0] base. A request in the same cycle as a write reads the old contents.
- R12: On success, `rsp_opsz` equals the operand-size bit of the selected descriptor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request strobe |
| req_sel | input | 16 | Segment selector |
| req_off | input | 32 | Offset within the segment |
| req_acc | input | 2 | Access kind (0 read, 1 write, 2 execute) |
| req_cpl | input | 2 | Current privilege level |
| wr_en | input | 1 | Descriptor write strobe |
| wr_addr | input | IDX_W+1 | Descriptor entry {bank, index} |
| wr_desc | input | 64 | Descriptor contents |
| rsp_valid | output | 1 | Response present |
| rsp_fault | output | 3 | Fault cause code |
| rsp_lin | output | 32 | Linear address |
| rsp_opsz | output | 1 | Operand size of the segment |

## Verification
Every translation result, fault code and operand-size bit becomes visible one rising edge after its request. The bench drives each request on a falling edge and compares the outputs on the next falling edge, half a period after the register updates. Descriptor writes take effect at the edge where they are presented. The same-cycle test therefore expects old data from the request that shares that edge, and new data from the request that follows it.

// File: rtl/segx_pkg.sv
package segx_pkg;

  typedef enum logic [2:0] {
    FLT_NONE   = 3'd0,
    FLT_ABSENT = 3'd1,
    FLT_LIMIT  = 3'd2,
    FLT_PRIV   = 3'd3,
    FLT_TYPE   = 3'd4
  } fault_e;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_EXEC  = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_e;

  typedef struct packed {
    logic        present;
    logic [1:0]  dpl;
    logic        gran;
    logic        opsz;
    logic        code;
    logic        perm;
    logic [4:0]  unused;
    logic [19:0] limit;
    logic [31:0] base;
  } desc_t;

endpackage

// File: rtl/segx_desc_table.sv
module segx_desc_table #(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [63:0]       wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [63:0]       rd_data
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [63:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  // Asynchronous read: old contents are seen during a same-cycle write (R11)
  assign rd_data = mem[rd_addr];

endmodule

// File: rtl/segx_check.sv
module segx_check
  import segx_pkg::*;
(
  input  desc_t       desc,
  input  logic        in_range,
  input  logic [1:0]  rpl,
  input  logic [1:0]  cpl,
  input  logic [1:0]  acc,
  input  logic [31:0] off,
  output fault_e      fault,
  output logic [31:0] lin,
  output logic        opsz
);
  logic [1:0]  eff_pl;
  logic [31:0] eff_lim;
  logic        priv_bad;
  logic        type_bad;
  logic        lim_bad;

  always_comb begin
    eff_pl   = (rpl > cpl) ? rpl : cpl;
    priv_bad = (eff_pl > desc.dpl);
    eff_lim  = desc.gran ? {desc.limit, 12'hFFF} : {12'h000, desc.limit};
    lim_bad  = (off > eff_lim);
    unique case (acc)
      ACC_READ:  type_bad = desc.code && !desc.perm;
      ACC_WRITE: type_bad = desc.code || !desc.perm;
      ACC_EXEC:  type_bad = !desc.code;
      default:   type_bad = 1'b1;
    endcase
  end

  always_comb begin
    if (!in_range || !desc.present) fault = FLT_ABSENT;
    else if (priv_bad)              fault = FLT_PRIV;
    else if (type_bad)              fault = FLT_TYPE;
    else if (lim_bad)               fault = FLT_LIMIT;
    else                            fault = FLT_NONE;
  end

  assign lin  = (fault == FLT_NONE) ? desc.base + off : 32'h0;
  assign opsz = (fault == FLT_NONE) ? desc.opsz : 1'b0;

endmodule

// File: rtl/segx_top.sv
module segx_top
  import segx_pkg::*;
#(
  parameter int IDX_W  = 3,
  parameter int SEL_W  = 16,
  parameter int OFF_W  = 32,
  parameter int ADDR_W = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [SEL_W-1:0]  req_sel,
  input  logic [OFF_W-1:0]  req_off,
  input  logic [1:0]        req_acc,
  input  logic [1:0]        req_cpl,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [63:0]       wr_desc,
  output logic              rsp_valid,
  output logic [2:0]        rsp_fault,
  output logic [OFF_W-1:0]  rsp_lin,
  output logic              rsp_opsz
);
  localparam int FULL_IDX_W = SEL_W - 3;

  logic [FULL_IDX_W-1:0] sel_idx;
  logic                  sel_bank;
  logic [1:0]            sel_rpl;
  logic                  idx_in_range;
  logic [ADDR_W-1:0]     rd_addr;
  logic [63:0]           rd_raw;
  desc_t                 rd_desc;
  fault_e                chk_fault;
  logic [31:0]           chk_lin;
  logic                  chk_opsz;

  // Selector split (R4)
  assign sel_idx      = req_sel[SEL_W-1:3];
  assign sel_bank     = req_sel[2];
  assign sel_rpl      = req_sel[1:0];
  assign idx_in_range = ((sel_idx >> IDX_W) == '0);
  assign rd_addr      = {sel_bank, sel_idx[IDX_W-1:0]};

  segx_desc_table #(.ADDR_W(ADDR_W)) u_table (
    .clk     (clk),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_desc),
    .rd_addr (rd_addr),
    .rd_data (rd_raw)
  );

  assign rd_desc = desc_t'(rd_raw);

  segx_check u_check (
    .desc     (rd_desc),
    .in_range (idx_in_range),
    .rpl      (sel_rpl),
    .cpl      (req_cpl),
    .acc      (req_acc),
    .off      (req_off),
    .fault    (chk_fault),
    .lin      (chk_lin),
    .opsz     (chk_opsz)
  );

  always_ff @(posedge clk) begin
    if (rst || !req_valid) begin
      rsp_valid <= 1'b0;
      rsp_fault <= 3'd0;
      rsp_lin   <= '0;
      rsp_opsz  <= 1'b0;
    end else begin
      rsp_valid <= 1'b1;
      rsp_fault <= chk_fault;
      rsp_lin   <= chk_lin;
      rsp_opsz  <= chk_opsz;
    end
  end

  AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid); // R2
  AST_NO_RSP_WITHOUT_REQ: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> (!rsp_valid && rsp_fault == 3'd0)); // R2
  AST_FAULT_CODE_LEGAL: assert property (@(posedge clk) disable iff (rst)
    rsp_fault <= 3'd4); // R3
  AST_LIN_CLEAR_ON_FAULT: assert property (@(posedge clk) disable iff (rst)
    (rsp_fault != 3'd0) |-> (rsp_lin == '0 && !rsp_opsz)); // R9
  AST_RANGE_IS_ABSENT: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !idx_in_range) |=> (rsp_fault == 3'd1)); // R4

endmodule

// File: tb/sim_segx_top.sv
module sim_segx_top;
  localparam int IDX_W  = 3;
  localparam int ADDR_W = IDX_W + 1;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              req_valid = 1'b0;
  logic [15:0]       req_sel = '0;
  logic [31:0]       req_off = '0;
  logic [1:0]        req_acc = '0;
  logic [1:0]        req_cpl = '0;
  logic              wr_en = 1'b0;
  logic [ADDR_W-1:0] wr_addr = '0;
  logic [63:0]       wr_desc = '0;
  logic              rsp_valid;
  logic [2:0]        rsp_fault;
  logic [31:0]       rsp_lin;
  logic              rsp_opsz;

  int n_checks = 0;
  int n_fails  = 0;

  always #10 clk = ~clk;

  segx_top #(.IDX_W(IDX_W)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_sel(req_sel),
    .req_off(req_off), .req_acc(req_acc), .req_cpl(req_cpl),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_desc(wr_desc),
    .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_lin(rsp_lin),
    .rsp_opsz(rsp_opsz)
  );

  function automatic logic [63:0] mk(input logic p, input logic [1:0] dpl,
      input logic g, input logic os, input logic code, input logic perm,
      input logic [19:0] lim, input logic [31:0] base);
    return {p, dpl, g, os, code, perm, 5'b0, lim, base};
  endfunction

  // {req[91:88], sel[87:72], off[71:40], acc[39:38], cpl[37:36], fault[35:33], lin[32:1], opsz[0]}
  localparam int NV = 24;
  localparam logic [91:0] VEC [NV] = '{
    {4'd9,  16'h0003, 32'h0000_0010, 2'd0, 2'd3, 3'd0, 32'h1000_0010, 1'b1}, // R9 data read
    {4'd8,  16'h0000, 32'h0000_0FFF, 2'd1, 2'd0, 3'd0, 32'h1000_0FFF, 1'b1}, // R8 at limit
    {4'd8,  16'h0000, 32'h0000_1000, 2'd0, 2'd0, 3'd2, 32'h0,         1'b0}, // R8 past limit
    {4'd8,  16'h0008, 32'h0000_2FFF, 2'd0, 2'd0, 3'd0, 32'h2000_2FFF, 1'b0}, // R8 granular edge
    {4'd8,  16'h0008, 32'h0000_3000, 2'd0, 2'd0, 3'd2, 32'h0,         1'b0}, // R8 granular over
    {4'd7,  16'h0008, 32'h0,         2'd1, 2'd0, 3'd4, 32'h0,         1'b0}, // R7 write read-only
    {4'd6,  16'h0008, 32'h0,         2'd0, 2'd1, 3'd3, 32'h0,         1'b0}, // R6 cpl too weak
    {4'd6,  16'h0009, 32'h0,         2'd0, 2'd0, 3'd3, 32'h0,         1'b0}, // R6 rpl too weak
    {4'd12, 16'h0013, 32'h0000_0100, 2'd2, 2'd3, 3'd0, 32'h0040_0100, 1'b0}, // R12 exec code
    {4'd7,  16'h0013, 32'h0,         2'd0, 2'd3, 3'd4, 32'h0,         1'b0}, // R7 read exec-only
    {4'd7,  16'h0013, 32'h0,         2'd1, 2'd3, 3'd4, 32'h0,         1'b0}, // R7 write code
    {4'd5,  16'h001B, 32'h0,         2'd0, 2'd3, 3'd1, 32'h0,         1'b0}, // R5 absent
    {4'd4,  16'h0006, 32'h0FFF_FFFF, 2'd0, 2'd2, 3'd0, 32'hFFFF_FFFF, 1'b1}, // R4 local bank
    {4'd9,  16'h0006, 32'h1000_0001, 2'd2, 2'd2, 3'd0, 32'h0000_0001, 1'b1}, // R9 wraparound
    {4'd7,  16'h0006, 32'h0,         2'd1, 2'd2, 3'd4, 32'h0,         1'b0}, // R7 write code
    {4'd6,  16'h0006, 32'h0,         2'd0, 2'd3, 3'd3, 32'h0,         1'b0}, // R6 dpl 2 vs 3
    {4'd11, 16'h000F, 32'h0,         2'd1, 2'd3, 3'd0, 32'h8000_0004, 1'b0}, // R11 local entry 1
    {4'd8,  16'h000F, 32'h0000_0001, 2'd1, 2'd3, 3'd2, 32'h0,         1'b0}, // R8 zero limit
    {4'd7,  16'h0003, 32'h0,         2'd2, 2'd3, 3'd4, 32'h0,         1'b0}, // R7 exec data
    {4'd7,  16'h0003, 32'h0,         2'd3, 2'd3, 3'd4, 32'h0,         1'b0}, // R7 reserved kind
    {4'd10, 16'h0008, 32'h0000_5000, 2'd1, 2'd3, 3'd3, 32'h0,         1'b0}, // R10 priv first
    {4'd10, 16'h001B, 32'hFFFF_FFFF, 2'd1, 2'd0, 3'd1, 32'h0,         1'b0}, // R10 absent first
    {4'd10, 16'h0013, 32'h0020_0000, 2'd1, 2'd3, 3'd4, 32'h0,         1'b0}, // R10 type over limit
    {4'd4,  16'h0040, 32'h0,         2'd0, 2'd0, 3'd1, 32'h0,         1'b0}  // R4 index out of range
  };

  task automatic compare(input int rq, input logic v, input logic [2:0] f,
                         input logic [31:0] l, input logic o);
    n_checks++;
    if (rsp_fault > 3'd4) begin // R3
      n_fails++;
      $display("FAIL R3: fault code %0d, expected 0..4", rsp_fault);
    end else if (rsp_valid !== v || rsp_fault !== f || rsp_lin !== l || rsp_opsz !== o) begin
      n_fails++;
      $display("FAIL R%0d: got v=%0b f=%0d lin=%h os=%0b, expected v=%0b f=%0d lin=%h os=%0b",
               rq, rsp_valid, rsp_fault, rsp_lin, rsp_opsz, v, f, l, o);
    end
  endtask

  task automatic put_req(input logic [15:0] s, input logic [31:0] o,
                         input logic [1:0] a, input logic [1:0] c);
    req_valid = 1'b1; req_sel = s; req_off = o; req_acc = a; req_cpl = c;
  endtask

  task automatic load(input int addr, input logic [63:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = ADDR_W'(addr); wr_desc = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    compare(1, 1'b0, 3'd0, 32'h0, 1'b0); // R1 during reset
    rst = 1'b0;
    for (int i = 0; i < (1 << ADDR_W); i++) load(i, 64'h0);
    compare(1, 1'b0, 3'd0, 32'h0, 1'b0); // R1 after reset, no request
    load(0, mk(1, 2'd3, 0, 1, 0, 1, 20'h00FFF, 32'h1000_0000));
    load(1, mk(1, 2'd0, 1, 0, 0, 0, 20'h00002, 32'h2000_0000));
    load(2, mk(1, 2'd3, 0, 0, 1, 0, 20'hFFFFF, 32'h0040_0000));
    load(3, mk(0, 2'd0, 0, 0, 0, 0, 20'h00000, 32'h0));
    load(8, mk(1, 2'd2, 1, 1, 1, 1, 20'hFFFFF, 32'hF000_0000));
    load(9, mk(1, 2'd3, 0, 0, 0, 1, 20'h00000, 32'h8000_0004));

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      put_req(VEC[i][87:72], VEC[i][71:40], VEC[i][39:38], VEC[i][37:36]);
      @(negedge clk);
      req_valid = 1'b0;
      compare(int'(VEC[i][91:88]), 1'b1, VEC[i][35:33], VEC[i][32:1], VEC[i][0]);
    end

    // R2: idle cycle gives no response
    @(negedge clk);
    compare(2, 1'b0, 3'd0, 32'h0, 1'b0);

    // R2: back-to-back requests
    @(negedge clk);
    put_req(16'h0003, 32'h0000_0020, 2'd0, 2'd3);
    @(negedge clk);
    compare(2, 1'b1, 3'd0, 32'h1000_0020, 1'b1);
    put_req(16'h0006, 32'h0000_0030, 2'd2, 2'd0);
    @(negedge clk);
    compare(2, 1'b1, 3'd0, 32'hF000_0030, 1'b1);
    req_valid = 1'b0;
    @(negedge clk);
    compare(2, 1'b0, 3'd0, 32'h0, 1'b0);

    // R11: same-cycle write returns old data, following request sees new data
    put_req(16'h0003, 32'h0000_0004, 2'd0, 2'd3);
    wr_en = 1'b1; wr_addr = '0;
    wr_desc = mk(1, 2'd3, 0, 0, 0, 1, 20'h00FFF, 32'h3000_0000);
    @(negedge clk);
    wr_en = 1'b0;
    compare(11, 1'b1, 3'd0, 32'h1000_0004, 1'b1);
    @(negedge clk);
    compare(11, 1'b1, 3'd0, 32'h3000_0004, 1'b0);
    req_valid = 1'b0;

    // R1: reset clears a pending response
    put_req(16'h0003, 32'h0, 2'd0, 2'd3);
    rst = 1'b1;
    @(negedge clk);
    compare(1, 1'b0, 3'd0, 32'h0, 1'b0);
    req_valid = 1'b0;
    rst = 1'b0;
    @(negedge clk);

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

endmodule